// File: doc/BRIEF.md
# Switch Packet Forwarding Decision Filter

This block makes the final forwarding verdict for each packet a switch receives. The address lookup is done outside the block. The block takes the lookup results for the packet's destination, the packet's own MAC addresses and its status flags, and two mode controls. From these it produces a registered result: either a drop or a mask of the egress ports. Port 0 is the host port; all other ports are network ports.

The block handles the special cases of switch forwarding. Aborted packets are discarded. Bypass mode sends all network traffic to the host. Frames with header errors and MAC control frames are steered to the host. A packet whose source equals its destination is rejected. Rate-limit, VLAN and vendor-prefix (OUI) deny checks can drop a packet, but supervisory destinations are exempt from them. A packet that reaches ordinary forwarding goes to the looked-up destination ports, never back out of the port it came in on.

Top module: `pkt_fwd_filter`

## Requirements
- R1: A result appears on `out_valid`/`out_drop`/`out_ports` exactly one clock after `in_valid` is high, and `out_valid` is low in every cycle that does not follow an `in_valid`. Reset clears all three outputs to zero.
- R2: A packet with `abort_seen` set is dropped, whatever the other inputs are.
- R3: With `bypass_en` set, a packet that arrives on a network port (ingress not 0) and is not aborted goes to the host only (`out_ports` = 3'b001), ignoring all drop checks. Packets arriving from the host are processed as in normal mode.
- R4: A non-aborted packet with `hdr_err` or `ctrl_frame` set goes to the host only if it came from a network port, and is dropped if it came from the host port.
- R5: Outside R2 to R4, a packet whose source MAC equals its destination MAC is dropped.
- R6: A non-supervisory packet with `rate_drop` or `vlan_drop` set is dropped.
- R7: With `oui_deny_en` set and `src_oui_hit` clear, every non-supervisory packet is dropped: unicast, multicast and broadcast (destination all ones).
- R8: A packet is supervisory when `dst_hit` is set and either the destination group bit (bit 40 of `dst_mac`) is set together with `dst_super`, or the group bit is clear and both `dst_block` and `dst_secure` are set. Supervisory packets are exempt from R6 and R7. A broadcast destination counts as a group address and needs `dst_super`.
- R9: A packet that reaches ordinary forwarding goes to `dst_ports` with the ingress port's bit cleared. If that mask is empty, the packet is dropped.
- R10: Whenever `out_drop` is high, `out_ports` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet descriptor present this cycle |
| ingress_port | input | 2 | Port the packet arrived on (0 = host) |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address |
| hdr_err | input | 1 | Packet carries a header error |
| ctrl_frame | input | 1 | Packet is a MAC control frame |
| abort_seen | input | 1 | Packet ended with an abort |
| dst_hit | input | 1 | Destination found in the address table |
| dst_super | input | 1 | Destination entry has the supervisory flag |
| dst_block | input | 1 | Destination entry has the block flag |
| dst_secure | input | 1 | Destination entry has the secure flag |
| dst_ports | input | 3 | Looked-up destination port mask |
| src_oui_hit | input | 1 | Source vendor prefix matches a table prefix entry |
| rate_drop | input | 1 | Rate limiter would drop this packet |
| vlan_drop | input | 1 | VLAN check would drop this packet |
| bypass_en | input | 1 | Bypass mode |
| oui_deny_en | input | 1 | Vendor-prefix deny mode |
| out_valid | output | 1 | Result valid |
| out_drop | output | 1 | Packet is dropped |
| out_ports | output | 3 | Egress port mask |

## Verification
Several overrides can apply to the same packet in the same cycle, so their priority has to be checked. The cases that collide are bypass steering with error steering, abort with bypass, and the supervisory exemption with a pending rate, VLAN or prefix drop. The bench builds descriptors that raise two such conditions in one `in_valid` cycle. It checks that the higher-priority outcome wins: abort beats bypass, bypass and error steering both give a host-only mask, and a supervisory entry survives a drop flag. The bench judges each result at the output one clock later.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      DST_UCAST = 2'd0,
      DST_MCAST = 2'd1,
      DST_BCAST = 2'd2
   } dst_kind_e;
endpackage

// File: rtl/pfd_classify.sv
module pfd_classify
   import pfd_pkg::*;
#(
   parameter int MAC_W     = 48,
   parameter int GROUP_BIT = 40
) (
   input  logic [MAC_W-1:0] dst_mac,
   input  logic             dst_hit,
   input  logic             dst_super,
   input  logic             dst_block,
   input  logic             dst_secure,
   output logic             is_super
);
   dst_kind_e kind;

   always_comb begin
      if (&dst_mac)
         kind = DST_BCAST;
      else if (dst_mac[GROUP_BIT])
         kind = DST_MCAST;
      else
         kind = DST_UCAST;
   end

   // group destinations (broadcast included) use the super flag,
   // individual ones need block and secure together
   always_comb begin
      if (!dst_hit)
         is_super = 1'b0;
      else if (kind == DST_UCAST)
         is_super = dst_block && dst_secure;
      else
         is_super = dst_super;
   end
endmodule

// File: rtl/pfd_mask.sv
module pfd_mask #(
   parameter int NUM_PORTS = 3,
   parameter int HOST_PORT = 0,
   localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [PW-1:0]        ingress_port,
   input  logic [NUM_PORTS-1:0] dst_ports,
   output logic [NUM_PORTS-1:0] fwd_mask,
   output logic [NUM_PORTS-1:0] host_mask,
   output logic                 from_host
);
   assign from_host = (ingress_port == PW'(HOST_PORT));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign fwd_mask[p]  = dst_ports[p] && (ingress_port != PW'(p));
      assign host_mask[p] = (p == HOST_PORT);
   end
endmodule

// File: rtl/pfd_verdict.sv
module pfd_verdict #(
   parameter int NUM_PORTS = 3
) (
   input  logic                 abort_seen,
   input  logic                 bypass_en,
   input  logic                 from_host,
   input  logic                 hdr_err,
   input  logic                 ctrl_frame,
   input  logic                 same_addr,
   input  logic                 is_super,
   input  logic                 rate_drop,
   input  logic                 vlan_drop,
   input  logic                 oui_deny_en,
   input  logic                 src_oui_hit,
   input  logic [NUM_PORTS-1:0] fwd_mask,
   input  logic [NUM_PORTS-1:0] host_mask,
   output logic                 drop,
   output logic [NUM_PORTS-1:0] ports
);
   logic filter_hit;

   assign filter_hit = rate_drop || vlan_drop || (oui_deny_en && !src_oui_hit);

   always_comb begin
      drop  = 1'b0;
      ports = fwd_mask;
      if (abort_seen)
         drop = 1'b1;
      else if (bypass_en && !from_host)
         ports = host_mask;
      else if (hdr_err || ctrl_frame) begin
         if (from_host) drop = 1'b1;
         else           ports = host_mask;
      end
      else if (same_addr)
         drop = 1'b1;
      else if (filter_hit && !is_super)
         drop = 1'b1;
      else if (fwd_mask == '0)
         drop = 1'b1;
      if (drop)
         ports = '0;
   end
endmodule

// File: rtl/pkt_fwd_filter.sv
module pkt_fwd_filter #(
   parameter int NUM_PORTS = 3,
   parameter int HOST_PORT = 0,
   parameter int MAC_W     = 48,
   parameter int GROUP_BIT = 40,
   localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [PW-1:0]        ingress_port,
   input  logic [MAC_W-1:0]     dst_mac,
   input  logic [MAC_W-1:0]     src_mac,
   input  logic                 hdr_err,
   input  logic                 ctrl_frame,
   input  logic                 abort_seen,
   input  logic                 dst_hit,
   input  logic                 dst_super,
   input  logic                 dst_block,
   input  logic                 dst_secure,
   input  logic [NUM_PORTS-1:0] dst_ports,
   input  logic                 src_oui_hit,
   input  logic                 rate_drop,
   input  logic                 vlan_drop,
   input  logic                 bypass_en,
   input  logic                 oui_deny_en,
   output logic                 out_valid,
   output logic                 out_drop,
   output logic [NUM_PORTS-1:0] out_ports
);
   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("pkt_fwd_filter: NUM_PORTS must be at least 2");
   end
   if (HOST_PORT < 0 || HOST_PORT >= NUM_PORTS) begin : g_bad_host
      $error("pkt_fwd_filter: HOST_PORT out of range");
   end
   if (GROUP_BIT < 0 || GROUP_BIT >= MAC_W) begin : g_bad_group
      $error("pkt_fwd_filter: GROUP_BIT outside the address");
   end

   logic                 is_super;
   logic                 from_host;
   logic                 same_addr;
   logic                 drop_d;
   logic [NUM_PORTS-1:0] fwd_mask;
   logic [NUM_PORTS-1:0] host_mask;
   logic [NUM_PORTS-1:0] ports_d;

   assign same_addr = (src_mac == dst_mac);

   pfd_classify #(.MAC_W(MAC_W), .GROUP_BIT(GROUP_BIT)) u_classify (
      .dst_mac    (dst_mac),
      .dst_hit    (dst_hit),
      .dst_super  (dst_super),
      .dst_block  (dst_block),
      .dst_secure (dst_secure),
      .is_super   (is_super)
   );

   pfd_mask #(.NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT)) u_mask (
      .ingress_port (ingress_port),
      .dst_ports    (dst_ports),
      .fwd_mask     (fwd_mask),
      .host_mask    (host_mask),
      .from_host    (from_host)
   );

   pfd_verdict #(.NUM_PORTS(NUM_PORTS)) u_verdict (
      .abort_seen  (abort_seen),
      .bypass_en   (bypass_en),
      .from_host   (from_host),
      .hdr_err     (hdr_err),
      .ctrl_frame  (ctrl_frame),
      .same_addr   (same_addr),
      .is_super    (is_super),
      .rate_drop   (rate_drop),
      .vlan_drop   (vlan_drop),
      .oui_deny_en (oui_deny_en),
      .src_oui_hit (src_oui_hit),
      .fwd_mask    (fwd_mask),
      .host_mask   (host_mask),
      .drop        (drop_d),
      .ports       (ports_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_drop  <= 1'b0;
         out_ports <= '0;
      end else begin
         out_valid <= in_valid;
         out_drop  <= in_valid && drop_d;
         out_ports <= in_valid ? ports_d : '0;
      end
   end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
   parameter int NUM_PORTS = 3,
   parameter int HOST_PORT = 0,
   parameter int MAC_W     = 48,
   parameter int GROUP_BIT = 40,
   localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [PW-1:0]        ingress_port,
   input logic [MAC_W-1:0]     dst_mac,
   input logic [MAC_W-1:0]     src_mac,
   input logic                 hdr_err,
   input logic                 ctrl_frame,
   input logic                 abort_seen,
   input logic                 dst_hit,
   input logic                 dst_super,
   input logic [NUM_PORTS-1:0] dst_ports,
   input logic                 bypass_en,
   input logic                 out_valid,
   input logic                 out_drop,
   input logic [NUM_PORTS-1:0] out_ports
);
   logic [NUM_PORTS-1:0] ing_oh;
   logic [NUM_PORTS-1:0] host_oh;
   logic                 net_in;
   logic                 plain;

   assign ing_oh  = NUM_PORTS'(1) << ingress_port;
   assign host_oh = NUM_PORTS'(1) << HOST_PORT;
   assign net_in  = (ingress_port != PW'(HOST_PORT));
   assign plain   = !abort_seen && !hdr_err && !ctrl_frame && !(bypass_en && net_in);

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_abort_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && abort_seen |=> out_drop);
   assert_bypass_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !abort_seen && bypass_en && net_in |=> !out_drop && out_ports == host_oh);
   assert_err_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !abort_seen && (hdr_err || ctrl_frame) && net_in
      |=> !out_drop && out_ports == host_oh);
   assert_same_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && plain && (src_mac == dst_mac) |=> out_drop);
   assert_super_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && plain && (src_mac != dst_mac) && dst_hit && dst_mac[GROUP_BIT] && dst_super
      && ((dst_ports & ~ing_oh) != '0) |=> !out_drop);
   assert_no_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_ports & $past(ing_oh)) == '0);
   assert_drop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_drop |-> out_ports == '0);
endmodule

bind pkt_fwd_filter pfd_checker #(
   .NUM_PORTS (NUM_PORTS),
   .HOST_PORT (HOST_PORT),
   .MAC_W     (MAC_W),
   .GROUP_BIT (GROUP_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .ingress_port (ingress_port),
   .dst_mac      (dst_mac),
   .src_mac      (src_mac),
   .hdr_err      (hdr_err),
   .ctrl_frame   (ctrl_frame),
   .abort_seen   (abort_seen),
   .dst_hit      (dst_hit),
   .dst_super    (dst_super),
   .dst_ports    (dst_ports),
   .bypass_en    (bypass_en),
   .out_valid    (out_valid),
   .out_drop     (out_drop),
   .out_ports    (out_ports)
);

// File: tb/pkt_fwd_filter_tb.sv
module pkt_fwd_filter_tb;
   localparam logic [47:0] UC = 48'h00_11_22_33_44_55;
   localparam logic [47:0] MC = 48'h01_00_5e_00_00_01;
   localparam logic [47:0] BC = 48'hff_ff_ff_ff_ff_ff;
   localparam logic [47:0] SA = 48'h00_aa_bb_cc_dd_ee;

   typedef struct packed {
      logic [1:0]  ing;
      logic [47:0] dst;
      logic [47:0] src;
      logic        herr, ctrl, abrt, hit, sup, blk, sec;
      logic [2:0]  dports;
      logic        oui, rate, vlan, byp, deny;
      logic        x_drop;
      logic [2:0]  x_ports;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   // fields: ing dst src herr ctrl abrt hit sup blk sec dports oui rate vlan byp deny | drop ports req
   localparam vec_t VECS [NV] = '{
      '{2'd1, UC, SA, 0,0,0, 1,0,0,0, 3'b101, 1,0,0,0,0, 0, 3'b101, 8'd9 },  // R9 plain
      '{2'd1, UC, SA, 0,0,0, 1,0,0,0, 3'b111, 1,0,0,0,0, 0, 3'b101, 8'd9 },  // R9 ingress removed
      '{2'd2, UC, SA, 0,0,0, 1,0,0,0, 3'b100, 1,0,0,0,0, 1, 3'b000, 8'd10},  // R10 empty mask
      '{2'd1, UC, SA, 0,0,1, 1,0,0,0, 3'b101, 1,0,0,0,0, 1, 3'b000, 8'd2 },  // R2 abort
      '{2'd2, UC, SA, 0,0,0, 1,0,0,0, 3'b011, 1,1,0,1,0, 0, 3'b001, 8'd3 },  // R3 bypass beats rate
      '{2'd0, UC, SA, 0,0,0, 1,0,0,0, 3'b110, 1,0,0,1,0, 0, 3'b110, 8'd3 },  // R3 host ingress normal
      '{2'd1, UC, SA, 1,0,0, 1,0,0,0, 3'b100, 1,0,0,0,0, 0, 3'b001, 8'd4 },  // R4 header error
      '{2'd0, UC, SA, 0,1,0, 1,0,0,0, 3'b110, 1,0,0,0,0, 1, 3'b000, 8'd4 },  // R4 control from host
      '{2'd1, UC, UC, 0,0,0, 1,0,0,0, 3'b101, 1,0,0,0,0, 1, 3'b000, 8'd5 },  // R5 same address
      '{2'd1, UC, SA, 0,0,0, 1,0,0,0, 3'b101, 1,1,0,0,0, 1, 3'b000, 8'd6 },  // R6 rate drop
      '{2'd1, UC, SA, 0,0,0, 1,0,1,1, 3'b101, 1,0,1,0,0, 0, 3'b101, 8'd8 },  // R8 unicast super beats vlan
      '{2'd1, UC, SA, 0,0,0, 1,0,0,0, 3'b101, 0,0,0,0,1, 1, 3'b000, 8'd7 },  // R7 unicast deny
      '{2'd1, UC, SA, 0,0,0, 1,0,1,0, 3'b101, 0,0,0,0,1, 1, 3'b000, 8'd7 },  // R7 block only
      '{2'd2, MC, SA, 0,0,0, 1,1,0,0, 3'b111, 0,0,0,0,1, 0, 3'b011, 8'd8 },  // R8 multicast super
      '{2'd1, BC, SA, 0,0,0, 1,0,0,0, 3'b111, 0,0,0,0,1, 1, 3'b000, 8'd7 },  // R7 broadcast deny
      '{2'd1, BC, SA, 0,0,0, 1,1,0,0, 3'b111, 0,0,0,0,1, 0, 3'b101, 8'd8 },  // R8 broadcast super
      '{2'd1, UC, SA, 0,0,0, 1,0,0,0, 3'b101, 1,0,0,0,1, 0, 3'b101, 8'd7 },  // R7 prefix hit passes
      '{2'd1, MC, SA, 0,0,0, 1,0,1,1, 3'b111, 1,1,0,0,0, 1, 3'b000, 8'd8 }   // R8 group needs super
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  ingress_port = '0;
   logic [47:0] dst_mac = '0, src_mac = '0;
   logic        hdr_err = 0, ctrl_frame = 0, abort_seen = 0, dst_hit = 0;
   logic        dst_super = 0, dst_block = 0, dst_secure = 0;
   logic [2:0]  dst_ports = '0;
   logic        src_oui_hit = 0, rate_drop = 0, vlan_drop = 0, bypass_en = 0, oui_deny_en = 0;
   logic        out_valid, out_drop;
   logic [2:0]  out_ports;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   pkt_fwd_filter u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ingress_port(ingress_port),
      .dst_mac(dst_mac), .src_mac(src_mac), .hdr_err(hdr_err), .ctrl_frame(ctrl_frame),
      .abort_seen(abort_seen), .dst_hit(dst_hit), .dst_super(dst_super),
      .dst_block(dst_block), .dst_secure(dst_secure), .dst_ports(dst_ports),
      .src_oui_hit(src_oui_hit), .rate_drop(rate_drop), .vlan_drop(vlan_drop),
      .bypass_en(bypass_en), .oui_deny_en(oui_deny_en),
      .out_valid(out_valid), .out_drop(out_drop), .out_ports(out_ports)
   );

   task automatic check(input string req, input logic v, input logic d, input logic [2:0] p);
      total++;
      if (out_valid !== v || out_drop !== d || out_ports !== p) begin
         bad++;
         $display("FAIL %s: got v=%b d=%b p=%b, want v=%b d=%b p=%b",
                  req, out_valid, out_drop, out_ports, v, d, p);
      end
   endtask

   task automatic drive(input vec_t t);
      in_valid = 1'b1;
      ingress_port = t.ing; dst_mac = t.dst; src_mac = t.src;
      hdr_err = t.herr; ctrl_frame = t.ctrl; abort_seen = t.abrt;
      dst_hit = t.hit; dst_super = t.sup; dst_block = t.blk; dst_secure = t.sec;
      dst_ports = t.dports; src_oui_hit = t.oui; rate_drop = t.rate;
      vlan_drop = t.vlan; bypass_en = t.byp; oui_deny_en = t.deny;
   endtask

   task automatic run(input vec_t t, input string req);
      @(negedge clk);
      drive(t);
      @(negedge clk);
      in_valid = 1'b0;
      check(req, 1'b1, t.x_drop, t.x_ports);
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      vec_t t;
      repeat (3) @(negedge clk);
      check("R1 reset", 1'b0, 1'b0, 3'b000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++)
         run(VECS[i], $sformatf("R%0d vec%0d", VECS[i].req, i));

      // R1: idle cycle after a result
      @(negedge clk);
      check("R1 idle", 1'b0, 1'b0, 3'b000);

      // R2 with R3 in one cycle: abort wins over bypass
      t = VECS[0]; t.abrt = 1; t.byp = 1; t.x_drop = 1; t.x_ports = 3'b000;
      run(t, "R2 abort+bypass");

      // R3 with R4 in one cycle: both steer to host
      t = VECS[0]; t.herr = 1; t.ctrl = 1; t.byp = 1; t.x_drop = 0; t.x_ports = 3'b001;
      run(t, "R3 bypass+error");

      // R8 with R6 and R7 together: broadcast super survives all filters
      t = VECS[15]; t.rate = 1; t.vlan = 1; t.x_drop = 0; t.x_ports = 3'b101;
      run(t, "R8 super vs all filters");

      // R1 back to back: two results in consecutive cycles
      @(negedge clk);
      drive(VECS[0]);
      @(negedge clk);
      drive(VECS[3]);
      check("R1 b2b first", 1'b1, 1'b0, 3'b101);
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 b2b second", 1'b1, 1'b1, 3'b000);
      @(negedge clk);
      check("R1 b2b idle", 1'b0, 1'b0, 3'b000);

      // R1: reset in mid-stream clears outputs
      drive(VECS[0]);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 async reset", 1'b0, 1'b0, 3'b000);
      rst_n = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule